// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a (segment, offset) pair into a flat linear address using segmentation with descriptor tables. Software first sets a global table register (base and 16-bit limit). It then loads a segment register by presenting a 16-bit selector. The unit reads the matching 8-byte descriptor through a simple memory read port, as two 32-bit words. It keeps the decoded base, the effective limit and the operand-size flag in a hidden per-segment cache.

Translations use only that cache. The linear address is the cached base plus the offset. Any offset past the effective limit raises a fault. A local table is set up by loading a selector that names a global-table descriptor, and that descriptor describes where the local table lies. While a descriptor fetch is running, the unit reports busy, stalls translation requests and ignores further load requests.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, busy, memRdEn, xlValid, loadDone and loadFault are 0 and every segOpSize32 bit is 0.
- R2: A segment load with selector S reads exactly two words: first at tableBase + S[15:3]*8, then at that address + 4. Bit 2 of S picks the local table (1) or the global table (0). Bits [1:0] are ignored.
- R3: A descriptor is decoded as follows. The low word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word holds base[23:16] in bits 7:0, limit[19:16] in bits 19:16, the operand-size flag in bit 22, the granularity flag in bit 23 and base[31:24] in bits 31:24. An accepted translation gives xlValid one cycle later, with xlLinear = base + offset modulo 2^32.
- R4: With granularity 0, an offset equal to the 20-bit limit translates without fault, and limit + 1 sets xlFault.
- R5: With granularity 1, the effective limit is {limit, 12'hFFF}.
- R6: If S[15:3]*8 + 7 exceeds the chosen table's limit, the load issues no read, pulses loadFault, and leaves the cache unchanged.
- R7: A local-table load (ldtWe) always fetches from the global table. The decoded base and effective limit then serve as the local table's base and limit. Before any such load, the local limit is 0.
- R8: busy is high from the cycle after a load is accepted until the descriptor is committed. While busy, translation requests produce no xlValid and load requests are ignored.
- R9: Translations never read memory. Changing table memory after a load does not change the translation result.
- R10: segOpSize32[n] equals the operand-size flag of the descriptor last loaded into segment n, and changes only when a load completes.
- R11: A successful load pulses loadDone for one cycle, in the first cycle in which busy is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gdtWe | input | 1 | Write global table register |
| gdtBaseIn | input | 32 | Global table base |
| gdtLimitIn | input | 16 | Global table limit |
| ldtWe | input | 1 | Start local-table descriptor load |
| ldtSelIn | input | 16 | Selector of the local-table descriptor |
| segWe | input | 1 | Start segment register load |
| segIdx | input | 2 | Target segment register |
| segSelIn | input | 16 | Selector written to the segment |
| memRdEn | output | 1 | One-cycle read request |
| memRdAddr | output | 32 | Read address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| xlReq | input | 1 | Translation request |
| xlSeg | input | 2 | Segment used for translation |
| xlOffset | input | 32 | Offset to translate |
| xlValid | output | 1 | Translation result valid |
| xlLinear | output | 32 | Linear address |
| xlFault | output | 1 | Limit violation |
| busy | output | 1 | Descriptor fetch in progress |
| loadDone | output | 1 | Load committed pulse |
| loadFault | output | 1 | Load aborted by table bound pulse |
| segOpSize32 | output | 4 | Per-segment 32-bit operand-size flag |

## Verification
The assertions check on every cycle the following rules. Read requests last one cycle and occur only while busy. A result appears only for a request made while idle. A fault result is always a valid one. The done and fault pulses never coincide and always fall in idle cycles. Operand-size flags move only when a load completes. The descriptor layout, the address arithmetic, the granularity scaling, the table bound abort, the local table indirection and the fact that the cache ignores later memory changes all depend on stored contents. Only the bench scenarios can show these, because they compare results against values worked out from the table images.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;

  typedef struct packed {
    logic latchReq;   // capture load request into pending registers
    logic issueRd;    // drive a read request this cycle
    logic addrHi;     // read address selects the upper descriptor word
    logic captLo;     // store the lower descriptor word
    logic commit;     // write decoded descriptor to its destination
  } ctrlStrobe_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;   // effective, already scaled
    logic              opSize32;
  } segCache_t;

  function automatic segCache_t decodeDesc(input logic [31:0] lo, input logic [31:0] hi);
    segCache_t r;
    logic [19:0] rawLimit;
    rawLimit   = {hi[19:16], lo[15:0]};
    r.base     = {hi[31:24], hi[7:0], lo[31:16]};
    r.limit    = hi[23] ? {rawLimit, 12'hFFF} : {12'h000, rawLimit};
    r.opSize32 = hi[22];
    return r;
  endfunction

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        segWe,
  input  logic        ldtWe,
  input  logic        outOfRange,
  input  logic        memRdValid,
  output ctrlStrobe_t strobe,
  output logic        memRdEn,
  output logic        busy,
  output logic        loadDone,
  output logic        loadFault
);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT_LO, S_WAIT_HI} state_t;

  state_t stateQ, stateD;
  logic   faultD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    faultD = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (segWe || ldtWe) begin
          strobe.latchReq = 1'b1;
          stateD          = S_CHECK;
        end
      end
      S_CHECK: begin
        if (outOfRange) begin
          faultD = 1'b1;
          stateD = S_IDLE;
        end else begin
          strobe.issueRd = 1'b1;
          stateD         = S_WAIT_LO;
        end
      end
      S_WAIT_LO: begin
        strobe.addrHi = 1'b1;
        if (memRdValid) begin
          strobe.captLo  = 1'b1;
          strobe.issueRd = 1'b1;
          stateD         = S_WAIT_HI;
        end
      end
      S_WAIT_HI: begin
        strobe.addrHi = 1'b1;
        if (memRdValid) begin
          strobe.commit = 1'b1;
          stateD        = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      loadDone  <= 1'b0;
      loadFault <= 1'b0;
    end else begin
      stateQ    <= stateD;
      loadDone  <= strobe.commit;
      loadFault <= faultD;
    end
  end

  assign memRdEn = strobe.issueRd;
  assign busy    = (stateQ != S_IDLE);

endmodule

// File: rtl/seg_xlate_dpath.sv
module seg_xlate_dpath
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              busy,
  input  logic              gdtWe,
  input  logic [ADDR_W-1:0] gdtBaseIn,
  input  logic [15:0]       gdtLimitIn,
  input  logic              segWe,
  input  logic [SEG_W-1:0]  segIdx,
  input  logic [SEL_W-1:0]  segSelIn,
  input  logic [SEL_W-1:0]  ldtSelIn,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              outOfRange,
  input  logic              xlReq,
  input  logic [SEG_W-1:0]  xlSeg,
  input  logic [ADDR_W-1:0] xlOffset,
  output logic              xlValid,
  output logic [ADDR_W-1:0] xlLinear,
  output logic              xlFault,
  output logic [NUM_SEGS-1:0] segOpSize32
);

  localparam int IDX_W = SEL_W - 3;

  // table registers
  logic [ADDR_W-1:0] gdtBaseQ, ldtBaseQ, ldtLimitQ;
  logic [15:0]       gdtLimitQ;

  // pending load
  logic [SEL_W-1:0]  pendSelQ;
  logic              pendIsLdtQ;
  logic [SEG_W-1:0]  pendSegQ;
  logic [31:0]       loWordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gdtBaseQ  <= '0;
      gdtLimitQ <= '0;
    end else if (gdtWe) begin
      gdtBaseQ  <= gdtBaseIn;
      gdtLimitQ <= gdtLimitIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSelQ   <= '0;
      pendIsLdtQ <= 1'b0;
      pendSegQ   <= '0;
      loWordQ    <= '0;
    end else begin
      if (strobe.latchReq) begin
        pendSelQ   <= segWe ? segSelIn : ldtSelIn;
        pendIsLdtQ <= !segWe;
        pendSegQ   <= segIdx;
      end
      if (strobe.captLo) loWordQ <= memRdData;
    end
  end

  // table selection and bound check
  logic              useLocal;
  logic [ADDR_W-1:0] tblBase, tblLimit, descOfs, descAddr;
  logic [IDX_W-1:0]  descIdx;

  always_comb begin
    useLocal  = !pendIsLdtQ && pendSelQ[2];
    descIdx   = pendSelQ[SEL_W-1:3];
    tblBase   = useLocal ? ldtBaseQ  : gdtBaseQ;
    tblLimit  = useLocal ? ldtLimitQ : {{(ADDR_W-16){1'b0}}, gdtLimitQ};
    descOfs   = {{(ADDR_W-SEL_W){1'b0}}, descIdx, 3'b000};
    descAddr  = tblBase + descOfs;
    outOfRange = ({1'b0, descOfs} + (ADDR_W+1)'(7)) > {1'b0, tblLimit};
    memRdAddr = descAddr + (strobe.addrHi ? ADDR_W'(4) : ADDR_W'(0));
  end

  segCache_t decoded;
  assign decoded = decodeDesc(loWordQ, memRdData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldtBaseQ  <= '0;
      ldtLimitQ <= '0;
    end else if (strobe.commit && pendIsLdtQ) begin
      ldtBaseQ  <= decoded.base;
      ldtLimitQ <= decoded.limit;
    end
  end

  // hidden descriptor cache, one entry per segment
  segCache_t cacheQ [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cacheQ[g] <= '0;
      end else if (strobe.commit && !pendIsLdtQ && (pendSegQ == SEG_W'(g))) begin
        cacheQ[g] <= decoded;
      end
    end
    assign segOpSize32[g] = cacheQ[g].opSize32;
  end

  // translation
  segCache_t selEntry;
  logic      accept;

  always_comb begin
    selEntry = cacheQ[xlSeg];
    accept   = xlReq && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlValid  <= 1'b0;
      xlLinear <= '0;
      xlFault  <= 1'b0;
    end else begin
      xlValid <= accept;
      if (accept) begin
        xlLinear <= selEntry.base + xlOffset;
        xlFault  <= xlOffset > selEntry.limit;
      end else begin
        xlFault  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                gdtWe,
  input  logic [31:0]         gdtBaseIn,
  input  logic [15:0]         gdtLimitIn,
  input  logic                ldtWe,
  input  logic [15:0]         ldtSelIn,
  input  logic                segWe,
  input  logic [SEG_W-1:0]    segIdx,
  input  logic [15:0]         segSelIn,
  output logic                memRdEn,
  output logic [31:0]         memRdAddr,
  input  logic                memRdValid,
  input  logic [31:0]         memRdData,
  input  logic                xlReq,
  input  logic [SEG_W-1:0]    xlSeg,
  input  logic [31:0]         xlOffset,
  output logic                xlValid,
  output logic [31:0]         xlLinear,
  output logic                xlFault,
  output logic                busy,
  output logic                loadDone,
  output logic                loadFault,
  output logic [NUM_SEGS-1:0] segOpSize32
);

  ctrlStrobe_t strobe;
  logic        outOfRange;

  seg_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .segWe      (segWe),
    .ldtWe      (ldtWe),
    .outOfRange (outOfRange),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .memRdEn    (memRdEn),
    .busy       (busy),
    .loadDone   (loadDone),
    .loadFault  (loadFault)
  );

  seg_xlate_dpath #(.NUM_SEGS(NUM_SEGS)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busy        (busy),
    .gdtWe       (gdtWe),
    .gdtBaseIn   (gdtBaseIn),
    .gdtLimitIn  (gdtLimitIn),
    .segWe       (segWe),
    .segIdx      (segIdx),
    .segSelIn    (segSelIn),
    .ldtSelIn    (ldtSelIn),
    .memRdData   (memRdData),
    .memRdAddr   (memRdAddr),
    .outOfRange  (outOfRange),
    .xlReq       (xlReq),
    .xlSeg       (xlSeg),
    .xlOffset    (xlOffset),
    .xlValid     (xlValid),
    .xlLinear    (xlLinear),
    .xlFault     (xlFault),
    .segOpSize32 (segOpSize32)
  );

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int NUM_SEGS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                memRdEn,
  input logic                xlReq,
  input logic                xlValid,
  input logic                xlFault,
  input logic                loadDone,
  input logic                loadFault,
  input logic [NUM_SEGS-1:0] segOpSize32
);

  p_read_only_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busy);

  p_read_single_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  p_fault_implies_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    xlFault |-> xlValid);

  p_abort_no_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    loadFault |-> (!busy && !$past(memRdEn)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    xlValid |-> $past(xlReq && !busy));

  p_opsize_on_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segOpSize32) |-> loadDone);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (!busy && !loadFault));

endmodule

bind seg_xlate_unit seg_xlate_checker #(.NUM_SEGS(NUM_SEGS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .memRdEn     (memRdEn),
  .xlReq       (xlReq),
  .xlValid     (xlValid),
  .xlFault     (xlFault),
  .loadDone    (loadDone),
  .loadFault   (loadFault),
  .segOpSize32 (segOpSize32)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gdtWe = 1'b0;
  logic [31:0] gdtBaseIn = '0;
  logic [15:0] gdtLimitIn = '0;
  logic        ldtWe = 1'b0;
  logic [15:0] ldtSelIn = '0;
  logic        segWe = 1'b0;
  logic [1:0]  segIdx = '0;
  logic [15:0] segSelIn = '0;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        xlReq = 1'b0;
  logic [1:0]  xlSeg = '0;
  logic [31:0] xlOffset = '0;
  logic        xlValid, xlFault, busy, loadDone, loadFault;
  logic [31:0] xlLinear;
  logic [3:0]  segOpSize32;

  always #2.5 clk = ~clk;

  seg_xlate_unit u_dut (.*);

  // memory model: two-cycle read latency
  logic [31:0] mem [0:255];
  logic        pipeV = 1'b0;
  logic [31:0] pipeA = '0;
  int          rdCount = 0;
  logic [31:0] rdLog [0:63];

  always @(posedge clk) begin
    pipeV      <= memRdEn;
    pipeA      <= memRdAddr;
    memRdValid <= pipeV;
    memRdData  <= pipeV ? mem[pipeA[9:2]] : 32'h0;
    if (memRdEn) begin
      rdLog[rdCount[5:0]] <= memRdAddr;
      rdCount <= rdCount + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkLo(input logic [31:0] base, input logic [19:0] lim);
    return {base[15:0], lim[15:0]};
  endfunction
  function automatic logic [31:0] mkHi(input logic [31:0] base, input logic [19:0] lim, input logic g, input logic d);
    return {base[31:24], g, d, 2'b00, lim[19:16], 8'h92, base[23:16]};
  endfunction
  task automatic putDesc(input logic [31:0] addr, input logic [31:0] base, input logic [19:0] lim, input logic g, input logic d);
    mem[addr[9:2]]       = mkLo(base, lim);
    mem[addr[9:2] + 8'd1] = mkHi(base, lim, g, d);
  endtask

  task automatic waitIdle(output logic done_o, output logic fault_o);
    done_o = 1'b0; fault_o = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busy) begin
        done_o = loadDone; fault_o = loadFault;
        return;
      end
    end
    check("R8", "busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic loadSeg(input logic [1:0] idx, input logic [15:0] sel, output logic done_o, output logic fault_o);
    segWe = 1'b1; segIdx = idx; segSelIn = sel;
    @(negedge clk);
    segWe = 1'b0;
    if (!busy) begin done_o = 1'b0; fault_o = 1'b0; check("R8", "busy after load", 32'd0, 32'd1); return; end
    waitIdle(done_o, fault_o);
  endtask

  task automatic loadLdt(input logic [15:0] sel, output logic done_o, output logic fault_o);
    ldtWe = 1'b1; ldtSelIn = sel;
    @(negedge clk);
    ldtWe = 1'b0;
    waitIdle(done_o, fault_o);
  endtask

  task automatic xlate(input string req, input logic [1:0] seg, input logic [31:0] ofs,
                       input logic [31:0] expLin, input logic expFault);
    xlReq = 1'b1; xlSeg = seg; xlOffset = ofs;
    @(negedge clk);
    xlReq = 1'b0;
    check(req, "xlValid", {31'd0, xlValid}, 32'd1);
    check(req, "xlFault", {31'd0, xlFault}, {31'd0, expFault});
    if (!expFault) check(req, "xlLinear", xlLinear, expLin);
  endtask

  task automatic tReset();
    check("R1", "busy", {31'd0, busy}, 32'd0);
    check("R1", "memRdEn", {31'd0, memRdEn}, 32'd0);
    check("R1", "xlValid", {31'd0, xlValid}, 32'd0);
    check("R1", "done/fault", {30'd0, loadDone, loadFault}, 32'd0);
    check("R1", "segOpSize32", {28'd0, segOpSize32}, 32'd0);
  endtask

  task automatic tGlobalLoad();
    logic d, f; int c0;
    c0 = rdCount;
    loadSeg(2'd0, 16'h000B, d, f);   // index 1, global, low bits set
    check("R11", "loadDone", {31'd0, d}, 32'd1);
    check("R2", "read count", rdCount - c0, 32'd2);
    check("R2", "first addr", rdLog[c0[5:0]], 32'h0000_0108);
    check("R2", "second addr", rdLog[c0[5:0] + 6'd1], 32'h0000_010C);
    check("R10", "opsize seg0", {28'd0, segOpSize32}, 32'h1);
    xlate("R3", 2'd0, 32'h0, 32'h1234_5678, 1'b0);
    xlate("R3", 2'd0, 32'h0000_0A10, 32'h1234_6088, 1'b0);
    xlate("R4", 2'd0, 32'h0000_0FFF, 32'h1234_6677, 1'b0);
    xlate("R4", 2'd0, 32'h0000_1000, 32'h0, 1'b1);
  endtask

  task automatic tGranular();
    logic d, f;
    loadSeg(2'd1, 16'h0010, d, f);
    check("R5", "loadDone", {31'd0, d}, 32'd1);
    xlate("R5", 2'd1, 32'h0000_2FFF, 32'h0040_2FFF, 1'b0);
    xlate("R5", 2'd1, 32'h0000_3000, 32'h0, 1'b1);
    check("R10", "opsize seg1 clear", {28'd0, segOpSize32}, 32'h1);
  endtask

  task automatic tTableBound();
    logic d, f; int c0;
    c0 = rdCount;
    loadSeg(2'd0, 16'h0040, d, f);   // index 8: 71 > 63
    check("R6", "loadFault", {31'd0, f}, 32'd1);
    check("R6", "no done", {31'd0, d}, 32'd0);
    check("R6", "no reads", rdCount - c0, 32'd0);
    xlate("R6", 2'd0, 32'h0, 32'h1234_5678, 1'b0);
    loadSeg(2'd2, 16'h0038, d, f);   // index 7: 63 fits exactly
    check("R6", "last entry loads", {30'd0, d, f}, 32'd2);
    xlate("R6", 2'd2, 32'h0, 32'h0, 1'b0);
    xlate("R4", 2'd2, 32'h1, 32'h0, 1'b1);
  endtask

  task automatic tLocal();
    logic d, f; int c0;
    loadSeg(2'd3, 16'h000C, d, f);   // local before setup: limit 0
    check("R7", "fault before setup", {31'd0, f}, 32'd1);
    c0 = rdCount;
    loadLdt(16'h0018, d, f);
    check("R7", "local setup done", {31'd0, d}, 32'd1);
    check("R7", "setup from global", rdLog[c0[5:0]], 32'h0000_0118);
    c0 = rdCount;
    loadSeg(2'd3, 16'h000C, d, f);
    check("R7", "local load done", {31'd0, d}, 32'd1);
    check("R7", "local addr", rdLog[c0[5:0]], 32'h0000_0208);
    xlate("R7", 2'd3, 32'h0000_01FF, 32'h0000_00FF, 1'b0);
    xlate("R7", 2'd3, 32'h0000_0400, 32'h0, 1'b1);
    check("R10", "opsize seg3", {28'd0, segOpSize32}, 32'h9);
    loadSeg(2'd3, 16'h0014, d, f);   // local index 2: 23 > 15
    check("R7", "local bound fault", {31'd0, f}, 32'd1);
  endtask

  task automatic tCache();
    int c0;
    putDesc(32'h108, 32'hABCD_0000, 20'h0FFFF, 1'b0, 1'b0);
    c0 = rdCount;
    xlate("R9", 2'd0, 32'h10, 32'h1234_5688, 1'b0);
    check("R9", "no reads on translate", rdCount - c0, 32'd0);
  endtask

  task automatic tStall();
    logic d, f;
    segWe = 1'b1; segIdx = 2'd1; segSelIn = 16'h0008;
    @(negedge clk);
    segWe = 1'b0;
    check("R8", "busy", {31'd0, busy}, 32'd1);
    xlReq = 1'b1; xlSeg = 2'd0; xlOffset = 32'h0;
    segWe = 1'b1; segIdx = 2'd2; segSelIn = 16'h0040;   // ignored
    @(negedge clk);
    xlReq = 1'b0; segWe = 1'b0;
    check("R8", "stalled xlValid", {31'd0, xlValid}, 32'd0);
    waitIdle(d, f);
    check("R8", "done not fault", {30'd0, d, f}, 32'd2);
    @(negedge clk);
    check("R8", "no late fault", {31'd0, loadFault}, 32'd0);
    xlate("R8", 2'd1, 32'h20, 32'hABCD_0020, 1'b0);
    xlate("R8", 2'd2, 32'h0, 32'h0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    putDesc(32'h108, 32'h1234_5678, 20'h00FFF, 1'b0, 1'b1);
    putDesc(32'h110, 32'h0040_0000, 20'h00002, 1'b1, 1'b0);
    putDesc(32'h118, 32'h0000_0200, 20'h0000F, 1'b0, 1'b0);
    putDesc(32'h208, 32'hFFFF_FF00, 20'h003FF, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    gdtWe = 1'b1; gdtBaseIn = 32'h100; gdtLimitIn = 16'h003F;
    @(negedge clk);
    gdtWe = 1'b0;
    tGlobalLoad();
    tGranular();
    tTableBound();
    tLocal();
    tCache();
    tStall();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule